// File: doc/BRIEF.md
# Cache line write merge buffer

This block gathers a burst of 32-bit word writes that all target one cache line and holds them in a line-wide buffer. Every word slot carries its own 4-bit byte enable. When the burst is closed, the block fetches the current contents of that line, fills in every byte whose enable is clear from the fetched copy, and then presents the whole line for commit. The commit carries a byte enable for each word, so the receiving storage changes only the bytes that the burst actually wrote.

A line is 64 bytes, which is 16 words of 32 bits. The word slot is given by address bits 5:2. The line address is the command address with its low 6 bits forced to zero. While the buffer is busy fetching or committing, the command side is stalled. A word that lands outside the line opened by the first word of the burst is dropped, and a one-cycle error pulse reports it.

Top module: `line_merge_buf`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cmd_ready` is 1 and `rd_req`, `wr_valid` and `err_line` are 0.
- R2: An accepted word with no burst open starts a burst. Its slot enable is set to `cmd_be` and every other slot enable is cleared. The enables appear on `wr_be`, word w at bits 4w+3:4w.
- R3: Each accepted word inside the open line writes its data and its enable into slot `cmd_addr[5:2]`, replacing any earlier value in that slot, and increments `wr_count`. The first word of a burst sets `wr_count` to 1.
- R4: Enable bit b of a word covers data bits 8b+7:8b (bit 0 is the lowest byte, bit 3 the highest byte).
- R5: In the merge step, every word becomes (buffered AND mask) OR (fetched AND NOT mask). A word with enable 0 takes the fetched word whole.
- R6: During commit, `wr_addr` is the line address with bits 5:0 zero. `wr_data` word w sits at bits 32w+31:32w. Storage that applies `wr_be` leaves enable-0 words untouched and replaces enable-F words whole.
- R7: `cmd_ready` is 1 while idle or collecting. It is 0 from the cycle after the end-of-packet word is accepted until the cycle after commit completes. A command offered while `cmd_ready` is 0 is not taken.
- R8: The cycle after the end-of-packet word is accepted, `rd_req` rises with `rd_addr` equal to the line address.
- R9: An accepted word whose line differs from the open line is not stored and not counted. `err_line` is 1 for exactly the next cycle. An end-of-packet flag on such a word still closes the burst.
- R10: `rd_req` stays high until `rd_valid` is seen, and the merge uses `rd_data` from that cycle. `wr_valid`, `wr_data` and `wr_be` hold steady until `wr_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_addr | input | ADDR_W | Byte address of the word |
| cmd_data | input | 32 | Word data |
| cmd_be | input | 4 | Byte enables of the word |
| cmd_eop | input | 1 | Last word of the burst |
| rd_req | output | 1 | Line fetch request |
| rd_addr | output | ADDR_W | Line address to fetch |
| rd_valid | input | 1 | Fetched line present on rd_data |
| rd_data | input | WORDS*32 | Fetched line, word w at bits 32w+31:32w |
| wr_valid | output | 1 | Merged line offered for commit |
| wr_ready | input | 1 | Commit accepted |
| wr_addr | output | ADDR_W | Line address of the commit |
| wr_data | output | WORDS*32 | Merged line |
| wr_be | output | WORDS*4 | Per-word byte enables |
| wr_count | output | $clog2(WORDS)+1 | Words stored in this burst |
| err_line | output | 1 | Pulse for a dropped off-line word |

## Verification
Every output is a register or is decoded from state, so each result appears one clock edge after the edge that took its cause. The fetch request follows the end-of-packet edge by one cycle. The merged line is presented one cycle after `rd_valid` is sampled. The error pulse follows the dropping edge by one cycle. The bench model advances on the same rising edge as the design and is compared against the outputs on the following falling edge, so every expected value is due exactly one edge after its stimulus. Stalled fetches and a held-off commit check that nothing moves early, and directed reads of the bench storage after each commit confirm the byte-level results.

// File: rtl/line_merge_buf.sv
module line_merge_buf #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic [ADDR_W-1:0]              cmd_addr,
  input  logic [31:0]                    cmd_data,
  input  logic [3:0]                     cmd_be,
  input  logic                           cmd_eop,
  output logic                           rd_req,
  output logic [ADDR_W-1:0]              rd_addr,
  input  logic                           rd_valid,
  input  logic [WORDS*32-1:0]            rd_data,
  output logic                           wr_valid,
  input  logic                           wr_ready,
  output logic [ADDR_W-1:0]              wr_addr,
  output logic [WORDS*32-1:0]            wr_data,
  output logic [WORDS*4-1:0]             wr_be,
  output logic [$clog2(WORDS):0]         wr_count,
  output logic                           err_line
);
  localparam int BYTES = 4;
  localparam int DW    = 8 * BYTES;
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFF_W = IDX_W + $clog2(BYTES);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_READ, S_COMMIT} st_t;

  st_t               st;
  logic [DW-1:0]     buf_q [WORDS];
  logic [BYTES-1:0]  be_q  [WORDS];
  logic [ADDR_W-1:0] line_q;
  logic [IDX_W:0]    cnt_q;
  logic              err_q;

  wire [IDX_W-1:0]  idx      = cmd_addr[OFF_W-1:OFF_W-IDX_W];
  wire [ADDR_W-1:0] cmd_line = {cmd_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
  wire              acc      = cmd_valid && cmd_ready;

  assign cmd_ready = (st == S_IDLE) || (st == S_COLLECT);
  assign rd_req    = (st == S_READ);
  assign rd_addr   = line_q;
  assign wr_valid  = (st == S_COMMIT);
  assign wr_addr   = line_q;
  assign wr_count  = cnt_q;
  assign err_line  = err_q;

  function automatic logic [DW-1:0] mask_of(input logic [BYTES-1:0] be);
    for (int b = 0; b < BYTES; b++) mask_of[8*b +: 8] = {8{be[b]}};
  endfunction

  for (genvar g = 0; g < WORDS; g++) begin : g_out
    assign wr_data[g*DW +: DW]      = buf_q[g];
    assign wr_be[g*BYTES +: BYTES]  = be_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      line_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      for (int w = 0; w < WORDS; w++) begin
        buf_q[w] <= '0;
        be_q[w]  <= '0;
      end
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE: if (acc) begin
          line_q <= cmd_line;
          cnt_q  <= 1;
          for (int w = 0; w < WORDS; w++)
            be_q[w] <= (IDX_W'(w) == idx) ? cmd_be : '0;
          buf_q[idx] <= cmd_data;
          st <= cmd_eop ? S_READ : S_COLLECT;
        end
        S_COLLECT: if (acc) begin
          if (cmd_line == line_q) begin
            buf_q[idx] <= cmd_data;
            be_q[idx]  <= cmd_be;
            cnt_q      <= cnt_q + 1'b1;
          end else begin
            err_q <= 1'b1;
          end
          if (cmd_eop) st <= S_READ;
        end
        S_READ: if (rd_valid) begin
          for (int w = 0; w < WORDS; w++)
            buf_q[w] <= (buf_q[w] & mask_of(be_q[w])) |
                        (rd_data[w*DW +: DW] & ~mask_of(be_q[w]));
          st <= S_COMMIT;
        end
        S_COMMIT: if (wr_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_EOP_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_eop |=> rd_req && rd_addr == $past(line_q == '0 && st == S_IDLE ? cmd_line : (st == S_IDLE ? cmd_line : line_q))); // R8
  AST_BUSY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req || wr_valid) |-> !cmd_ready); // R7
  AST_FETCH_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req); // R10
  AST_COMMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data) && $stable(wr_be) && $stable(wr_addr)); // R10
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && st == S_COLLECT && cmd_line != line_q |=> err_line && $stable(wr_count) && $stable(wr_be)); // R9
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_line |=> !err_line || $past(acc && st == S_COLLECT && cmd_line != line_q)); // R9
endmodule

// File: tb/line_merge_buf_tb_top.sv
module line_merge_buf_tb_top;
  localparam int ADDR_W = 32;
  localparam int WORDS  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_eop = 1'b0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic [3:0] cmd_be = '0;
  logic rd_stall = 1'b0, wr_ready = 1'b1;
  logic cmd_ready, rd_req, rd_valid, wr_valid, err_line;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORDS*32-1:0] rd_data, wr_data;
  logic [WORDS*4-1:0] wr_be;
  logic [4:0] wr_count;

  logic [31:0] mem [4][WORDS];
  int checks = 0, errors = 0;

  int ph = 0, mcnt = 0;
  logic [31:0] mline = '0;
  logic [31:0] mb [WORDS];
  logic [3:0] me [WORDS];
  logic merr = 1'b0;

  always #2 clk = ~clk;

  assign rd_valid = rd_req && !rd_stall;
  for (genvar g = 0; g < WORDS; g++) begin : g_rd
    assign rd_data[g*32 +: 32] = mem[rd_addr[7:6]][g];
  end

  line_merge_buf #(.ADDR_W(ADDR_W), .WORDS(WORDS)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_be(cmd_be), .cmd_eop(cmd_eop),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_count(wr_count), .err_line(err_line));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < WORDS; w++) mem[l][w] = 32'h1000_0000 * l + 32'h0101_0101 * w;
    for (int w = 0; w < WORDS; w++) begin mb[w] = '0; me[w] = '0; end
  end

  // behavioural reference model, advanced on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; mcnt = 0; mline = '0; merr = 1'b0;
      for (int w = 0; w < WORDS; w++) begin mb[w] = '0; me[w] = '0; end
    end else begin
      merr = 1'b0;
      if (ph == 0 && cmd_valid) begin
        mline = cmd_addr & ~32'h3F;
        for (int w = 0; w < WORDS; w++) me[w] = 4'h0;
        me[cmd_addr[5:2]] = cmd_be;
        mb[cmd_addr[5:2]] = cmd_data;
        mcnt = 1;
        ph = cmd_eop ? 2 : 1;
      end else if (ph == 1 && cmd_valid) begin
        if ((cmd_addr & ~32'h3F) == mline) begin
          me[cmd_addr[5:2]] = cmd_be;
          mb[cmd_addr[5:2]] = cmd_data;
          mcnt++;
        end else merr = 1'b1;
        if (cmd_eop) ph = 2;
      end else if (ph == 2 && rd_valid) begin
        for (int w = 0; w < WORDS; w++)
          for (int b = 0; b < 4; b++)
            if (!me[w][b]) mb[w][8*b +: 8] = mem[mline[7:6]][w][8*b +: 8];
        ph = 3;
      end else if (ph == 3 && wr_ready) begin
        for (int w = 0; w < WORDS; w++)
          for (int b = 0; b < 4; b++)
            if (me[w][b]) mem[mline[7:6]][w][8*b +: 8] = mb[w][8*b +: 8];
        ph = 0;
      end
    end
  end

  always @(negedge clk) begin
    chk(cmd_ready == (ph <= 1), "R7 cmd_ready", 64'(cmd_ready), 64'(ph <= 1));
    chk(rd_req == (ph == 2), "R8 rd_req", 64'(rd_req), 64'(ph == 2));
    chk(wr_valid == (ph == 3), "R6 wr_valid", 64'(wr_valid), 64'(ph == 3));
    chk(err_line == merr, "R9 err_line", 64'(err_line), 64'(merr));
    if (ph == 2) chk(rd_addr == mline, "R8 rd_addr", 64'(rd_addr), 64'(mline));
    if (ph == 3) begin
      chk(wr_addr == mline, "R6 wr_addr", 64'(wr_addr), 64'(mline));
      chk(wr_count == 5'(mcnt), "R3 wr_count", 64'(wr_count), 64'(mcnt));
      for (int w = 0; w < WORDS; w++) begin
        chk(wr_data[w*32 +: 32] == mb[w], "R5 merged word", 64'(wr_data[w*32 +: 32]), 64'(mb[w]));
        chk(wr_be[w*4 +: 4] == me[w], "R2 word enable", 64'(wr_be[w*4 +: 4]), 64'(me[w]));
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be, input logic eop);
    cmd_addr = a; cmd_data = d; cmd_be = be; cmd_eop = eop; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_eop = 1'b0;
  endtask

  task automatic wait_idle();
    while (!cmd_ready) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    @(negedge clk);
    chk(cmd_ready && !rd_req && !wr_valid && !err_line, "R1 reset outputs",
        64'({cmd_ready, rd_req, wr_valid, err_line}), 64'(4'b1000));
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready && !rd_req && !wr_valid && !err_line, "R1 after reset",
        64'({cmd_ready, rd_req, wr_valid, err_line}), 64'(4'b1000));

    // single word, bytes 0 and 2
    send(32'h0000_004C, 32'hAABB_CCDD, 4'b0101, 1'b1);
    wait_idle();
    chk(mem[1][3] == 32'h13BB_03DD, "R4 byte lanes", 64'(mem[1][3]), 64'h13BB_03DD);
    chk(mem[1][4] == 32'h1404_0404, "R6 untouched word", 64'(mem[1][4]), 64'h1404_0404);

    // multi-word burst with a rewritten slot and a zero-enable word
    send(32'h0000_0080, 32'h1111_1111, 4'hF, 1'b0);
    @(negedge clk);
    send(32'h0000_0094, 32'hEE00_0000, 4'h8, 1'b0);
    send(32'h0000_0080, 32'h2222_2222, 4'h3, 1'b0);
    send(32'h0000_00BC, 32'hFFFF_FFFF, 4'h0, 1'b1);
    wait_idle();
    chk(mem[2][0] == 32'h2000_2222, "R3 slot rewrite", 64'(mem[2][0]), 64'h2000_2222);
    chk(mem[2][5] == 32'hEE05_0505, "R4 top byte", 64'(mem[2][5]), 64'hEE05_0505);
    chk(mem[2][15] == 32'h2F0F_0F0F, "R6 zero enable", 64'(mem[2][15]), 64'h2F0F_0F0F);

    // off-line word dropped
    send(32'h0000_00C4, 32'h5A5A_5A5A, 4'hF, 1'b0);
    send(32'h0000_0004, 32'hDEAD_BEEF, 4'hF, 1'b0);
    send(32'h0000_00C8, 32'h0000_0077, 4'h1, 1'b1);
    wait_idle();
    chk(mem[0][1] == 32'h0101_0101, "R9 dropped word", 64'(mem[0][1]), 64'h0101_0101);
    chk(mem[3][2] == 32'h3202_0277, "R5 low byte merge", 64'(mem[3][2]), 64'h3202_0277);

    // off-line word carrying end-of-packet closes the burst
    send(32'h0000_0040, 32'h0000_0099, 4'h1, 1'b0);
    send(32'h0000_0100, 32'h1234_5678, 4'hF, 1'b1);
    wait_idle();
    chk(mem[1][0] == 32'h1000_0099, "R9 eop on dropped word", 64'(mem[1][0]), 64'h1000_0099);

    // stalled fetch and held commit, with a command waiting meanwhile
    rd_stall = 1'b1; wr_ready = 1'b0;
    send(32'h0000_0008, 32'hCAFE_F00D, 4'hF, 1'b1);
    cmd_addr = 32'h0000_000C; cmd_data = 32'h0BAD_0BAD; cmd_be = 4'hF; cmd_eop = 1'b1; cmd_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk(rd_req && !cmd_ready, "R10 fetch held", 64'({rd_req, cmd_ready}), 64'(2'b10));
    rd_stall = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_valid && !cmd_ready, "R10 commit held", 64'({wr_valid, cmd_ready}), 64'(2'b10));
    chk(mem[0][3] == 32'h0303_0303, "R7 command not taken while busy", 64'(mem[0][3]), 64'h0303_0303);
    wr_ready = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_eop = 1'b0;
    wait_idle();
    chk(mem[0][2] == 32'hCAFE_F00D, "R6 full word", 64'(mem[0][2]), 64'hCAFE_F00D);
    chk(mem[0][3] == 32'h0BAD_0BAD, "R7 queued command", 64'(mem[0][3]), 64'h0BAD_0BAD);

    repeat (3) @(negedge clk);
    report();
  end
endmodule